// File: doc/BRIEF.md
# Hotplug Slot Status Register Controller

This controller keeps hot-insert and hot-remove bookkeeping for up to 32 slots on each of a parameterised number of buses. Platform logic reports a newly hot-added device with a plug event and a removal request with an unplug event. Each event sets one status bit on its bus and raises a one-cycle event pulse. Firmware then looks at the status through a small 32-bit register window.

The window is indirect. A select register chooses the bus, and every status read returns that bus's words. In normal mode, reading the insert word hands back the pending bits and clears them. In legacy mode the insert word is left intact and the select register always holds the default bus. Writing a slot mask to the eject offset makes the block take the lowest set bit. It retires that slot's insert and remove bits and issues a one-cycle eject command naming the bus and slot. A re-initialisation request first drains every pending remove bit, one eject per cycle. It then reloads each bus's removable mask from the non-removable input. The same sequence runs after the asynchronous reset.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After rst_n is released, busy is high until initialisation ends. After that, all insert and remove words read zero, each removable word reads the bitwise inverse of that bus's 32-bit slice of nonremovable, and the select register reads DEFAULT_BUS (0).
- R2: Register offsets are 0x00 insert status, 0x04 remove status, 0x08 feature word (always reads 0), 0x0C removable mask and 0x10 bus select. A read's value appears on reg_rdata in the cycle after the access and is held until the next read. Any other offset reads 0.
- R3: An access acts only when reg_be is 4'hF. Any other byte-enable pattern reads as 0, writes nothing and clears nothing.
- R4: While the select value is NUM_BUS or above, reads of 0x00, 0x04, 0x08 and 0x0C return 0. A read of 0x10 always returns the full stored 32-bit select value.
- R5: In normal mode, a read of 0x00 on a valid bus returns the insert bits and clears exactly those bits. In legacy mode (legacy_mode=1) the same read leaves them set.
- R6: A write to 0x10 stores the written word. In legacy mode it stores DEFAULT_BUS instead.
- R7: A write of a nonzero mask to 0x08 picks the lowest set bit as the slot and clears that slot's insert and remove bits on the selected bus. eject_valid pulses in the next cycle with eject_bus set to the selected bus and eject_slot set to that bit index. A zero mask, an out-of-range select, or busy makes the write do nothing.
- R8: plug_valid sets insert bit plug_slot of bus plug_bus. unplug_valid sets remove bit unplug_slot of bus unplug_bus. Either event makes evt_pulse high for the following cycle.
- R9: If a status bit is set by an event in the same cycle that a read or an eject clears it, the bit ends up set. A read in that cycle returns the value from before the event.
- R10: A reinit pulse raises busy. It ejects every pending remove bit in ascending bus order, and in ascending slot order within a bus, one per cycle. It then reloads the removable masks from nonremovable. Register writes are ignored while busy.
- R11: Writes to 0x00, 0x04 and 0x0C have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Legacy behaviour for select writes and insert reads |
| reinit | input | 1 | Start the drain and mask reload sequence |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset in the window |
| reg_be | input | 4 | Byte enables, only 4'hF acts |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| plug_valid | input | 1 | Hot-add event |
| plug_bus | input | BW | Bus of the hot-add event |
| plug_slot | input | 5 | Slot of the hot-add event |
| unplug_valid | input | 1 | Removal request event |
| unplug_bus | input | BW | Bus of the removal request |
| unplug_slot | input | 5 | Slot of the removal request |
| nonremovable | input | NUM_BUS*32 | Per-bus slots that cannot be removed |
| busy | output | 1 | Initialisation sequence in progress |
| evt_pulse | output | 1 | One-cycle event notification |
| eject_valid | output | 1 | One-cycle eject command |
| eject_bus | output | BW | Bus to eject on |
| eject_slot | output | 5 | Slot to eject |

## Verification
Every result comes from a single register stage, so each is due exactly one cycle after the edge that samples its stimulus: read data, the event pulse, the eject command, and the status words changed by events, reads and ejects. The bench drives on the falling edge and reads the result on the next falling edge, after the one rising edge in between. It then leaves one idle cycle before the next stimulus, so each check sees exactly one update. The drain sequence lasts a data-dependent number of cycles. For that, the bench logs eject commands as they appear and polls busy, then compares the order of the log against a list it computes from its own model of the remove bits.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int SLOT_W = 5;
  localparam int NSLOT  = 32;
  localparam int DW     = 32;

  localparam logic [4:0] OFF_INS  = 5'h00;
  localparam logic [4:0] OFF_REM  = 5'h04;
  localparam logic [4:0] OFF_FEAT = 5'h08;
  localparam logic [4:0] OFF_RMV  = 5'h0C;
  localparam logic [4:0] OFF_SEL  = 5'h10;

  typedef enum logic {ST_RUN = 1'b0, ST_INIT = 1'b1} seq_e;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hp_status_bank.sv
module hp_status_bank
  import hp_slot_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int BW      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_set_en,
  input  logic [BW-1:0]           ins_set_bus,
  input  logic [SLOT_W-1:0]       ins_set_slot,
  input  logic                    rem_set_en,
  input  logic [BW-1:0]           rem_set_bus,
  input  logic [SLOT_W-1:0]       rem_set_slot,
  input  logic                    rdclr_en,
  input  logic [BW-1:0]           rdclr_bus,
  input  logic [DW-1:0]           rdclr_bits,
  input  logic                    ej_en,
  input  logic [BW-1:0]           ej_bus,
  input  logic [SLOT_W-1:0]       ej_slot,
  input  logic                    mask_load,
  input  logic [NUM_BUS*DW-1:0]   nonrem,
  output logic [NUM_BUS*DW-1:0]   ins_flat,
  output logic [NUM_BUS*DW-1:0]   rem_flat,
  output logic [NUM_BUS*DW-1:0]   rmv_flat
);
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [DW-1:0] ins_q, rem_q, rmv_q;
    logic [DW-1:0] ins_d, rem_d, rmv_d;
    logic [DW-1:0] ins_set, rem_set, ins_clr, rem_clr, ej_bit;
    logic          ins_upd, rem_upd;

    always_comb begin
      ins_set = (ins_set_en && ins_set_bus == BW'(b)) ? (DW'(1) << ins_set_slot) : '0;
      rem_set = (rem_set_en && rem_set_bus == BW'(b)) ? (DW'(1) << rem_set_slot) : '0;
      ej_bit  = (ej_en && ej_bus == BW'(b)) ? (DW'(1) << ej_slot) : '0;
      ins_clr = ej_bit | ((rdclr_en && rdclr_bus == BW'(b)) ? rdclr_bits : '0);
      rem_clr = ej_bit;
      // a set in the same cycle overrides any clear
      ins_d   = (ins_q & ~ins_clr) | ins_set;
      rem_d   = (rem_q & ~rem_clr) | rem_set;
      ins_upd = |(ins_set | ins_clr);
      rem_upd = |(rem_set | rem_clr);
      rmv_d   = ~nonrem[b*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ins_q <= '0;
        rem_q <= '0;
        rmv_q <= '1;
      end else begin
        if (ins_upd)   ins_q <= ins_d;
        if (rem_upd)   rem_q <= rem_d;
        if (mask_load) rmv_q <= rmv_d;
      end
    end

    assign ins_flat[b*DW +: DW] = ins_q;
    assign rem_flat[b*DW +: DW] = rem_q;
    assign rmv_flat[b*DW +: DW] = rmv_q;
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int NUM_BUS     = 4,
  parameter int DEFAULT_BUS = 0,
  parameter int BW          = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  legacy_mode,
  input  logic                  reinit,
  input  logic                  reg_valid,
  input  logic                  reg_write,
  input  logic [4:0]            reg_addr,
  input  logic [3:0]            reg_be,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  plug_valid,
  input  logic [BW-1:0]         plug_bus,
  input  logic [4:0]            plug_slot,
  input  logic                  unplug_valid,
  input  logic [BW-1:0]         unplug_bus,
  input  logic [4:0]            unplug_slot,
  input  logic [NUM_BUS*32-1:0] nonremovable,
  output logic                  busy,
  output logic                  evt_pulse,
  output logic                  eject_valid,
  output logic [BW-1:0]         eject_bus,
  output logic [4:0]            eject_slot
);
  localparam logic [BW-1:0] LAST_BUS = BW'(NUM_BUS - 1);

  seq_e              state_q, state_d;
  logic [BW-1:0]     idx_q, idx_d;
  logic              state_upd;
  logic [DW-1:0]     sel_q, sel_d;
  logic              sel_upd;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              rdata_upd;
  logic              evt_q, evt_d;
  logic              ejv_q, ejv_d;
  logic [BW-1:0]     ejb_q;
  logic [SLOT_W-1:0] ejs_q;

  logic [NUM_BUS*DW-1:0] ins_flat, rem_flat, rmv_flat;
  logic                  acc_ok, rd_en, wr_en, sel_ok;
  logic [BW-1:0]         sel_bus;
  logic [DW-1:0]         ins_cur, rem_cur, rmv_cur, rem_drain, rd_val;
  logic                  rdclr_en, wr_ej, drain_ej, drain_done, mask_load;
  logic                  plug_ok, unplug_ok, ej_en;
  logic [SLOT_W-1:0]     wr_slot, drain_slot, ej_slot;
  logic [BW-1:0]         ej_bus;

  // access decode
  always_comb begin
    acc_ok  = reg_valid && (reg_be == 4'hF);
    rd_en   = acc_ok && !reg_write;
    wr_en   = acc_ok && reg_write && (state_q == ST_RUN);
    sel_ok  = (sel_q < DW'(NUM_BUS));
    sel_bus = sel_q[BW-1:0];
    ins_cur = ins_flat[int'(sel_bus)*DW +: DW];
    rem_cur = rem_flat[int'(sel_bus)*DW +: DW];
    rmv_cur = rmv_flat[int'(sel_bus)*DW +: DW];
    rem_drain = rem_flat[int'(idx_q)*DW +: DW];
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == OFF_SEL) begin
      rd_val = sel_q;
    end else if (sel_ok) begin
      case (reg_addr)
        OFF_INS: rd_val = ins_cur;
        OFF_REM: rd_val = rem_cur;
        OFF_RMV: rd_val = rmv_cur;
        default: rd_val = '0;
      endcase
    end
  end

  hp_lowbit #(.W(DW), .IW(SLOT_W)) u_wr_low   (.vec(reg_wdata), .idx(wr_slot));
  hp_lowbit #(.W(DW), .IW(SLOT_W)) u_drain_low(.vec(rem_drain), .idx(drain_slot));

  // side effects
  always_comb begin
    rdclr_en   = rd_en && (reg_addr == OFF_INS) && sel_ok && !legacy_mode;
    wr_ej      = wr_en && (reg_addr == OFF_FEAT) && sel_ok && (reg_wdata != '0);
    drain_ej   = (state_q == ST_INIT) && (rem_drain != '0);
    drain_done = (state_q == ST_INIT) && (rem_drain == '0) && (idx_q == LAST_BUS);
    mask_load  = drain_done;
    ej_en      = drain_ej || wr_ej;
    ej_bus     = drain_ej ? idx_q : sel_bus;
    ej_slot    = drain_ej ? drain_slot : wr_slot;
    plug_ok    = plug_valid && (int'(plug_bus) < NUM_BUS);
    unplug_ok  = unplug_valid && (int'(unplug_bus) < NUM_BUS);
  end

  // sequencer next state
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    state_upd = 1'b0;
    if (state_q == ST_RUN) begin
      if (reinit) begin
        state_d   = ST_INIT;
        idx_d     = '0;
        state_upd = 1'b1;
      end
    end else if (drain_done) begin
      state_d   = ST_RUN;
      state_upd = 1'b1;
    end else if (!drain_ej) begin
      idx_d     = idx_q + BW'(1);
      state_upd = 1'b1;
    end
  end

  // register next values
  always_comb begin
    sel_upd   = wr_en && (reg_addr == OFF_SEL);
    sel_d     = legacy_mode ? DW'(DEFAULT_BUS) : reg_wdata;
    rdata_upd = reg_valid && !reg_write;
    rdata_d   = acc_ok ? rd_val : '0;
    evt_d     = plug_ok || unplug_ok;
    ejv_d     = ej_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      idx_q   <= '0;
      sel_q   <= DW'(DEFAULT_BUS);
      rdata_q <= '0;
      evt_q   <= 1'b0;
      ejv_q   <= 1'b0;
      ejb_q   <= '0;
      ejs_q   <= '0;
    end else begin
      if (state_upd) begin
        state_q <= state_d;
        idx_q   <= idx_d;
      end
      if (sel_upd)   sel_q   <= sel_d;
      if (rdata_upd) rdata_q <= rdata_d;
      evt_q <= evt_d;
      ejv_q <= ejv_d;
      if (ej_en) begin
        ejb_q <= ej_bus;
        ejs_q <= ej_slot;
      end
    end
  end

  hp_status_bank #(.NUM_BUS(NUM_BUS), .BW(BW)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_set_en  (plug_ok),
    .ins_set_bus (plug_bus),
    .ins_set_slot(plug_slot),
    .rem_set_en  (unplug_ok),
    .rem_set_bus (unplug_bus),
    .rem_set_slot(unplug_slot),
    .rdclr_en    (rdclr_en),
    .rdclr_bus   (sel_bus),
    .rdclr_bits  (ins_cur),
    .ej_en       (ej_en),
    .ej_bus      (ej_bus),
    .ej_slot     (ej_slot),
    .mask_load   (mask_load),
    .nonrem      (nonremovable),
    .ins_flat    (ins_flat),
    .rem_flat    (rem_flat),
    .rmv_flat    (rmv_flat)
  );

  assign reg_rdata   = rdata_q;
  assign busy        = (state_q == ST_INIT);
  assign evt_pulse   = evt_q;
  assign eject_valid = ejv_q;
  assign eject_bus   = ejb_q;
  assign eject_slot  = ejs_q;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int NUM_BUS     = 4,
  parameter int DEFAULT_BUS = 0,
  parameter int BW          = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          legacy_mode,
  input logic          reg_valid,
  input logic          reg_write,
  input logic [4:0]    reg_addr,
  input logic [3:0]    reg_be,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          plug_valid,
  input logic [BW-1:0] plug_bus,
  input logic          busy,
  input logic          evt_pulse,
  input logic          eject_valid,
  input logic [BW-1:0] eject_bus,
  input logic [4:0]    eject_slot,
  input logic [31:0]   sel_q
);
  logic full_wr, full_rd;
  assign full_wr = reg_valid && reg_write && (reg_be == 4'hF);
  assign full_rd = reg_valid && !reg_write && (reg_be == 4'hF);

  a_r8_plug_event: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_valid && int'(plug_bus) < NUM_BUS) |=> evt_pulse);

  a_r7_eject_lowbit: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && reg_addr == 5'h08 && !busy && sel_q < 32'(NUM_BUS) && reg_wdata != 32'd0)
    |=> (eject_valid && eject_bus == $past(sel_q[BW-1:0])
         && ((($past(reg_wdata) >> eject_slot) & 32'd1) == 32'd1)
         && (($past(reg_wdata) & ((32'd1 << eject_slot) - 32'd1)) == 32'd0)));

  a_r7_eject_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (eject_valid && !$past(busy)) |-> $past(full_wr && reg_addr == 5'h08));

  a_r4_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rd && sel_q >= 32'(NUM_BUS) && reg_addr != 5'h10) |=> reg_rdata == 32'd0);

  a_r6_legacy_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && legacy_mode && !busy && reg_addr == 5'h10) |=> sel_q == 32'(DEFAULT_BUS));

  a_r10_busy_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && full_wr && reg_addr == 5'h10) |=> $stable(sel_q));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.NUM_BUS(NUM_BUS), .DEFAULT_BUS(DEFAULT_BUS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .reg_valid(reg_valid),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .plug_valid(plug_valid), .plug_bus(plug_bus), .busy(busy),
  .evt_pulse(evt_pulse), .eject_valid(eject_valid), .eject_bus(eject_bus),
  .eject_slot(eject_slot), .sel_q(sel_q)
);

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  localparam int NB = 4;
  localparam int BW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, legacy_mode, reinit, reg_valid, reg_write;
  logic [4:0] reg_addr;
  logic [3:0] reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic plug_valid, unplug_valid;
  logic [BW-1:0] plug_bus, unplug_bus, eject_bus;
  logic [4:0] plug_slot, unplug_slot, eject_slot;
  logic [NB*32-1:0] nonremovable;
  logic busy, evt_pulse, eject_valid;

  hp_slot_ctrl #(.NUM_BUS(NB), .DEFAULT_BUS(0)) uut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .reinit(reinit),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .plug_valid(plug_valid),
    .plug_bus(plug_bus), .plug_slot(plug_slot), .unplug_valid(unplug_valid),
    .unplug_bus(unplug_bus), .unplug_slot(unplug_slot), .nonremovable(nonremovable),
    .busy(busy), .evt_pulse(evt_pulse), .eject_valid(eject_valid),
    .eject_bus(eject_bus), .eject_slot(eject_slot));

  int checks = 0, fails = 0;
  logic [31:0] m_ins [NB];
  logic [31:0] m_rem [NB];
  logic [31:0] m_rmv [NB];
  logic [31:0] m_sel;
  int ej_n = 0;
  logic [1:0] ej_lb [64];
  logic [4:0] ej_ls [64];

  always @(negedge clk) begin
    if (eject_valid && ej_n < 64) begin
      ej_lb[ej_n] = eject_bus;
      ej_ls[ej_n] = eject_slot;
      ej_n = ej_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    if (a == 5'h10) return m_sel;
    if (m_sel >= NB) return 32'd0;
    case (a)
      5'h00: return m_ins[m_sel];
      5'h04: return m_rem[m_sel];
      5'h0C: return m_rmv[m_sel];
      default: return 32'd0;
    endcase
  endfunction

  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    rd = reg_rdata;
  endtask

  task automatic rdx(input string req, input logic [4:0] a);
    logic [31:0] v;
    access(1'b0, a, 32'd0, 4'hF, v);
    check(req, v, exp_read(a));
    if (a == 5'h00 && !legacy_mode && m_sel < NB) m_ins[m_sel] = 32'd0;
  endtask

  task automatic wsel(input logic [31:0] d);
    logic [31:0] v;
    access(1'b1, 5'h10, d, 4'hF, v);
    m_sel = legacy_mode ? 32'd0 : d;
  endtask

  task automatic plug(input int b, input int s);
    @(negedge clk);
    plug_valid = 1'b1; plug_bus = BW'(b); plug_slot = 5'(s);
    @(negedge clk);
    plug_valid = 1'b0;
    check("R8 plug evt", {31'd0, evt_pulse}, 32'd1);
    m_ins[b] |= 32'd1 << s;
  endtask

  task automatic unplug(input int b, input int s);
    @(negedge clk);
    unplug_valid = 1'b1; unplug_bus = BW'(b); unplug_slot = 5'(s);
    @(negedge clk);
    unplug_valid = 1'b0;
    check("R8 unplug evt", {31'd0, evt_pulse}, 32'd1);
    m_rem[b] |= 32'd1 << s;
  endtask

  task automatic eject_chk(input string req, input logic [31:0] d);
    logic [31:0] v;
    int mark, s;
    mark = ej_n;
    access(1'b1, 5'h08, d, 4'hF, v);
    @(negedge clk);
    if (m_sel < NB && d != 0) begin
      s = lowest(d);
      check({req, " count"}, 32'(ej_n - mark), 32'd1);
      check({req, " bus"}, 32'(ej_lb[mark]), m_sel);
      check({req, " slot"}, 32'(ej_ls[mark]), 32'(s));
      m_ins[m_sel] &= ~(32'd1 << s);
      m_rem[m_sel] &= ~(32'd1 << s);
    end else begin
      check({req, " none"}, 32'(ej_n - mark), 32'd0);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic dump_bus(input string req, input int b);
    wsel(32'(b));
    rdx(req, 5'h04);
    rdx(req, 5'h0C);
    rdx(req, 5'h08);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int mark, n_exp;
    int eb [64];
    int es [64];
    rst_n = 1'b0; legacy_mode = 1'b0; reinit = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
    reg_addr = '0; reg_be = '0; reg_wdata = '0; plug_valid = 1'b0; unplug_valid = 1'b0;
    plug_bus = '0; plug_slot = '0; unplug_bus = '0; unplug_slot = '0;
    for (int b = 0; b < NB; b++) nonremovable[b*32 +: 32] = (32'd1 << b) | 32'h8000_0000;
    for (int b = 0; b < NB; b++) begin
      m_ins[b] = 0; m_rem[b] = 0; m_rmv[b] = ~((32'd1 << b) | 32'h8000_0000);
    end
    m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 32'd1);
    wait_idle();

    // R1 / R2: reset state over every bus and offset
    rdx("R1 select reset", 5'h10);
    for (int b = 0; b < NB; b++) begin
      wsel(32'(b));
      rdx("R1 insert reset", 5'h00);
      dump_bus("R1 R2 reset words", b);
    end
    rdx("R2 unmapped offset", 5'h14);

    // R8 / R5: plug sweep over buses and slots
    for (int b = 0; b < NB; b++) begin
      plug(b, 0); plug(b, b + 5); plug(b, 31);
    end
    for (int b = 0; b < NB; b++) begin
      wsel(32'(b));
      rdx("R5 R8 insert read", 5'h00);
      rdx("R5 insert cleared", 5'h00);
    end

    // R8: unplug sweep, remove word is not clear-on-read
    for (int b = 0; b < NB; b++) begin
      unplug(b, 2 * b + 1); unplug(b, 20 + b);
    end
    for (int b = 0; b < NB; b++) begin
      wsel(32'(b));
      rdx("R8 remove read", 5'h04);
      rdx("R8 remove held", 5'h04);
    end

    // R7: eject decoding of lowest bit
    wsel(32'd2);
    plug(2, 5);
    eject_chk("R7 eject", 32'h0010_0028);
    eject_chk("R7 eject", 32'h8000_0000);
    eject_chk("R7 zero mask", 32'd0);
    rdx("R7 remove after eject", 5'h04);
    rdx("R7 insert after eject", 5'h00);

    // R4: out-of-range select
    wsel(32'd7);
    rdx("R4 sel readback", 5'h10);
    rdx("R4 oob insert", 5'h00);
    rdx("R4 oob remove", 5'h04);
    rdx("R4 oob mask", 5'h0C);
    eject_chk("R4 R7 oob eject", 32'h0000_0002);

    // R3: partial byte enables
    wsel(32'd1);
    plug(1, 12);
    access(1'b0, 5'h00, 32'd0, 4'h3, v);
    check("R3 partial read zero", v, 32'd0);
    access(1'b1, 5'h10, 32'd3, 4'h1, v);
    rdx("R3 partial write ignored", 5'h10);
    rdx("R3 no clear on partial", 5'h00);

    // R11: writes to read-only offsets
    plug(1, 14);
    access(1'b1, 5'h00, 32'hFFFF_FFFF, 4'hF, v);
    access(1'b1, 5'h04, 32'hFFFF_FFFF, 4'hF, v);
    access(1'b1, 5'h0C, 32'h0000_0000, 4'hF, v);
    rdx("R11 mask unchanged", 5'h0C);
    rdx("R11 remove unchanged", 5'h04);
    rdx("R11 insert unchanged", 5'h00);

    // R6 / R5 legacy mode
    legacy_mode = 1'b1;
    wsel(32'd3);
    rdx("R6 legacy select forced", 5'h10);
    plug(0, 9);
    rdx("R5 legacy insert", 5'h00);
    rdx("R5 legacy not cleared", 5'h00);
    legacy_mode = 1'b0;
    rdx("R5 normal clears", 5'h00);
    rdx("R5 normal cleared", 5'h00);

    // R9: set and clear in the same cycle
    wsel(32'd1);
    plug(1, 2);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 5'h00; reg_be = 4'hF;
    plug_valid = 1'b1; plug_bus = 2'd1; plug_slot = 5'd9;
    @(negedge clk);
    reg_valid = 1'b0; plug_valid = 1'b0;
    check("R9 read pre-event value", reg_rdata, m_ins[1]);
    m_ins[1] = 32'd1 << 9;
    rdx("R9 new insert kept", 5'h00);
    unplug(1, 6);
    mark = ej_n;
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 5'h08; reg_be = 4'hF; reg_wdata = 32'd1 << 6;
    unplug_valid = 1'b1; unplug_bus = 2'd1; unplug_slot = 5'd6;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; unplug_valid = 1'b0;
    @(negedge clk);
    check("R9 eject issued", 32'(ej_n - mark), 32'd1);
    rdx("R9 remove kept", 5'h04);

    // R10: reinit drain order and mask reload
    unplug(3, 0); unplug(0, 30);
    for (int b = 0; b < NB; b++) nonremovable[b*32 +: 32] = 32'h0000_00F0 << b;
    n_exp = 0;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 32; s++)
        if (m_rem[b][s]) begin eb[n_exp] = b; es[n_exp] = s; n_exp++; end
    mark = ej_n;
    wsel(32'd2);
    @(negedge clk); reinit = 1'b1;
    @(negedge clk); reinit = 1'b0;
    check("R10 busy on reinit", {31'd0, busy}, 32'd1);
    access(1'b1, 5'h10, 32'd0, 4'hF, v);
    wait_idle();
    @(negedge clk);
    check("R10 drain count", 32'(ej_n - mark), 32'(n_exp));
    for (int i = 0; i < n_exp; i++) begin
      check("R10 drain bus", 32'(ej_lb[mark + i]), 32'(eb[i]));
      check("R10 drain slot", 32'(ej_ls[mark + i]), 32'(es[i]));
      m_ins[eb[i]] &= ~(32'd1 << es[i]);
    end
    for (int b = 0; b < NB; b++) begin
      m_rem[b] = 0;
      m_rmv[b] = ~(32'h0000_00F0 << b);
    end
    rdx("R10 select held while busy", 5'h10);
    for (int b = 0; b < NB; b++) begin
      dump_bus("R10 after drain", b);
      rdx("R10 insert after drain", 5'h00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule